// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Tracking

This block buffers received characters for a host. Each byte arrives from a receiver together with three error flags: break, framing and parity. Byte and flags are stored side by side in one FIFO entry. The host pops the oldest entry by reading the receive holding register. The block always presents that entry's byte and its three flags, and presents zeros when nothing is stored.

A tally of the stored entries that carry any error flag drives a summary bit. The summary bit stays set while an erroneous entry remains anywhere in the FIFO, even when the head entry is clean. A write that arrives while the FIFO is full is dropped and raises an overrun flag. The host clears that flag by reading the line status register.

The occupancy is kept by a fill state machine with three states:
- `FILL_EMPTY`: goes to `FILL_PART` on an accepted write.
- `FILL_PART`: goes to `FILL_FULL` on a write without a pop that fills the last slot. It goes to `FILL_EMPTY` on a pop without a write that removes the last entry. Otherwise it stays.
- `FILL_FULL`: goes to `FILL_PART` on a pop.

The overrun flag has its own two-state machine:
- `OVR_CLEAR`: goes to `OVR_HELD` on a write made while full.
- `OVR_HELD`: goes back to `OVR_CLEAR` on a line status read that does not coincide with a new overrun.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset `empty`=1, `err_any`=0, `overrun`=0, and `rd_data` and all head flags are 0.
- R2: Bytes leave in the order they were written. Up to DEPTH (default 64) entries are held.
- R3: `head_brk`, `head_frm` and `head_par` show the flags stored with the head entry. A pop updates them to the flags of the next entry in the cycle after the pop.
- R4: While the FIFO is empty, `rd_data` and the three head flags read 0.
- R5: `err_any` is 1 exactly while at least one stored entry has any of its three flags set. It clears in the cycle after the last such entry is popped.
- R6: A write while the FIFO is full is dropped. The stored contents and the order are unchanged, and `overrun` is 1 from the next cycle.
- R7: `overrun` returns to 0 in the cycle after `lsr_rd` is asserted. If a write to a full FIFO happens in the same cycle as `lsr_rd`, `overrun` stays 1.
- R8: A pop request while the FIFO is empty changes no state: the block stays empty, `err_any` stays 0 and the outputs stay 0.
- R9: A write and a pop in the same cycle keep the occupancy unchanged. The error tally is adjusted by both the entering entry and the leaving entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Receiver presents a character |
| wr_data | input | DATA_W | Received byte |
| wr_brk | input | 1 | Break flag of the received byte |
| wr_frm | input | 1 | Framing-error flag of the received byte |
| wr_par | input | 1 | Parity-error flag of the received byte |
| rd_en | input | 1 | Host read of the receive holding register (pop) |
| lsr_rd | input | 1 | Host read of the line status register |
| rd_data | output | DATA_W | Byte at the head, 0 when empty |
| head_brk | output | 1 | Break flag of the head entry, 0 when empty |
| head_frm | output | 1 | Framing flag of the head entry, 0 when empty |
| head_par | output | 1 | Parity flag of the head entry, 0 when empty |
| err_any | output | 1 | Some stored entry carries an error flag |
| overrun | output | 1 | A write was dropped because the FIFO was full |
| empty | output | 1 | No entries stored |

## Verification
The FIFO is filled to its full depth with an arithmetic byte sequence. Errors are sprinkled with a period of seven, so every combination of flags appears. Draining it then separates the summary bit from the head flags, because clean heads pass while errors remain further back. Writes to a full FIFO, with and without a coinciding line status read, distinguish a drop from an overwrite, and distinguish which of set or clear wins. A run of simultaneous writes and pops, and a short clean–error–clean sequence, exercise the tally arithmetic and the moment the summary bit falls.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxf_flags_t;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_t;

    typedef enum logic {
        OVR_CLEAR = 1'b0,
        OVR_HELD  = 1'b1
    } ovr_state_t;

endpackage

// File: rtl/rxf_fill_fsm.sv
module rxf_fill_fsm
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] fill_cnt,
    output logic             full,
    output logic             empty
);

    fill_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (push) state_d = FILL_PART;
            end
            FILL_PART: begin
                if (push && !pop && fill_cnt == CNT_W'(DEPTH - 1))
                    state_d = FILL_FULL;
                else if (pop && !push && fill_cnt == CNT_W'(1))
                    state_d = FILL_EMPTY;
            end
            FILL_FULL: begin
                if (pop && !push) state_d = FILL_PART;
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        empty = (state_q == FILL_EMPTY);
        full  = (state_q == FILL_FULL);
    end

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   fill_cnt <= fill_cnt + CNT_W'(1);
                2'b01:   fill_cnt <= fill_cnt - CNT_W'(1);
                default: fill_cnt <= fill_cnt;
            endcase
        end
    end

    // R9: simultaneous push and pop leaves occupancy unchanged
    a_r9_both_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop |=> $stable(fill_cnt));
    // R2: state and count agree
    a_r2_empty_state_count: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (fill_cnt == '0));
    a_r2_full_state_count: assert property (@(posedge clk) disable iff (!rst_n)
        full == (fill_cnt == CNT_W'(DEPTH)));

endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int ENT_W = DATA_W + 3
) (
    input  logic              clk,
    input  logic              push,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [DATA_W-1:0] in_data,
    input  rxf_flags_t        in_flags,
    output logic [DATA_W-1:0] head_data,
    output rxf_flags_t        head_flags
);

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= {in_flags, in_data};
    end

    always_comb begin
        head_data  = mem[rd_ptr][DATA_W-1:0];
        head_flags = mem[rd_ptr][ENT_W-1:DATA_W];
    end

endmodule

// File: rtl/rxf_err_tally.sv
module rxf_err_tally #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_err,
    input  logic             sub_err,
    output logic [CNT_W-1:0] err_cnt,
    output logic             err_any
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else begin
            unique case ({add_err, sub_err})
                2'b10:   err_cnt <= err_cnt + CNT_W'(1);
                2'b01:   err_cnt <= err_cnt - CNT_W'(1);
                default: err_cnt <= err_cnt;
            endcase
        end
    end

    assign err_any = (err_cnt != '0);

    // R5: tally never underflows
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        sub_err && !add_err |-> err_cnt != '0);

endmodule

// File: rtl/rxf_ovr_fsm.sv
module rxf_ovr_fsm
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_set,
    input  logic ovr_clr,
    output logic overrun
);

    ovr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OVR_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_CLEAR: if (ovr_set) state_d = OVR_HELD;
            OVR_HELD:  if (ovr_clr && !ovr_set) state_d = OVR_CLEAR;
            default:   state_d = OVR_CLEAR;
        endcase
    end

    always_comb begin
        overrun = (state_q == OVR_HELD);
    end

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_brk,
    input  logic              wr_frm,
    input  logic              wr_par,
    input  logic              rd_en,
    input  logic              lsr_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              head_brk,
    output logic              head_frm,
    output logic              head_par,
    output logic              err_any,
    output logic              overrun,
    output logic              empty
);

    logic             full;
    logic             push;
    logic             pop;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] err_cnt;
    logic [DATA_W-1:0] mem_data;
    rxf_flags_t       mem_flags;
    rxf_flags_t       in_flags;

    assign in_flags = '{brk: wr_brk, frm: wr_frm, par: wr_par};
    assign push     = wr_en && !full;
    assign pop      = rd_en && !empty;

    rxf_fill_fsm #(.DEPTH(DEPTH)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .fill_cnt (fill_cnt),
        .full     (full),
        .empty    (empty)
    );

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .push       (push),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .in_data    (wr_data),
        .in_flags   (in_flags),
        .head_data  (mem_data),
        .head_flags (mem_flags)
    );

    rxf_err_tally #(.DEPTH(DEPTH)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_err (push && (|in_flags)),
        .sub_err (pop && (|mem_flags)),
        .err_cnt (err_cnt),
        .err_any (err_any)
    );

    rxf_ovr_fsm u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovr_set (wr_en && full),
        .ovr_clr (lsr_rd),
        .overrun (overrun)
    );

    // head presentation, zero while empty
    always_comb begin
        rd_data  = empty ? '0 : mem_data;
        head_brk = !empty && mem_flags.brk;
        head_frm = !empty && mem_flags.frm;
        head_par = !empty && mem_flags.par;
    end

    // R5: erroneous entries are a subset of the stored entries
    a_r5_err_within_fill: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= fill_cnt);
    a_r5_empty_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !err_any);
    // R3: a flagged head implies the summary bit
    a_r3_head_implies_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (head_brk || head_frm || head_par) |-> err_any);
    // R6: a write to a full FIFO raises overrun and leaves it full
    a_r6_full_write_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && full |=> overrun);
    a_r6_full_write_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && full && !rd_en |=> full && $stable(err_cnt));
    // R7: a line status read clears overrun unless a new drop coincides
    a_r7_lsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !(wr_en && full) |=> !overrun);
    // R8: a pop request on an empty FIFO is inert
    a_r8_empty_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_en && !wr_en |=> empty && $stable(err_cnt));

endmodule

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_brk = 1'b0, wr_frm = 1'b0, wr_par = 1'b0;
    logic              rd_en = 1'b0, lsr_rd = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              head_brk, head_frm, head_par, err_any, overrun, empty;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // model: {brk,frm,par,data}
    logic [DATA_W+2:0] mq[$];
    logic m_ovr = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rx_err_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_err_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par),
        .rd_en(rd_en), .lsr_rd(lsr_rd), .rd_data(rd_data),
        .head_brk(head_brk), .head_frm(head_frm), .head_par(head_par),
        .err_any(err_any), .overrun(overrun), .empty(empty)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [DATA_W-1:0] e_data;
        logic [2:0]        e_flg;
        logic              e_err;
        e_err = 1'b0;
        foreach (mq[k]) if (mq[k][DATA_W+2:DATA_W] != 3'b0) e_err = 1'b1;
        if (mq.size() == 0) begin
            e_data = '0;
            e_flg  = 3'b0;
        end else begin
            e_data = mq[0][DATA_W-1:0];
            e_flg  = mq[0][DATA_W+2:DATA_W];
        end
        check(tag, "empty",   32'(empty), 32'(mq.size() == 0));
        check(tag, "rd_data", 32'(rd_data), 32'(e_data));
        check(tag, "flags",   32'({head_brk, head_frm, head_par}), 32'(e_flg));
        check(tag, "err_any", 32'(err_any), 32'(e_err));
        check(tag, "overrun", 32'(overrun), 32'(m_ovr));
    endtask

    // one clock: inputs driven at negedge, outputs checked at next negedge
    task automatic cyc(input logic we, input logic [DATA_W-1:0] d,
                       input logic [2:0] f, input logic re, input logic lr,
                       input string tag);
        logic was_full;
        wr_en = we; wr_data = d; {wr_brk, wr_frm, wr_par} = f;
        rd_en = re; lsr_rd = lr;
        was_full = (mq.size() == DEPTH);
        if (re && mq.size() > 0) void'(mq.pop_front());
        if (we && !was_full) mq.push_back({f, d});
        if (we && was_full) m_ovr = 1'b1;
        else if (lr) m_ovr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; lsr_rd = 1'b0;
        check_all(tag);
    endtask

    function automatic logic [DATA_W-1:0] pat_data(input int i);
        return DATA_W'((i * 37 + 5) % 256);
    endfunction

    function automatic logic [2:0] pat_flag(input int i);
        return (i % 7 == 3) ? 3'((i / 7) % 7 + 1) : 3'b0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R8: pop and status read on empty FIFO
        for (int i = 0; i < 4; i++) cyc(1'b0, '0, 3'b0, 1'b1, i[0], "R8");

        // R2: fill to full depth with sprinkled errors
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, pat_data(i), pat_flag(i), 1'b0, 1'b0, "R2");

        // R6: writes while full dropped, overrun raised
        cyc(1'b1, 8'hEE, 3'b111, 1'b0, 1'b0, "R6");
        cyc(1'b1, 8'hDD, 3'b000, 1'b0, 1'b0, "R6");
        // R7: status read clears; coinciding drop keeps it set
        cyc(1'b0, '0, 3'b0, 1'b0, 1'b1, "R7");
        cyc(1'b1, 8'hCC, 3'b010, 1'b0, 1'b1, "R7");
        cyc(1'b0, '0, 3'b0, 1'b0, 1'b1, "R7");
        // R6: full, write plus pop in same cycle: write still dropped
        cyc(1'b1, 8'hBB, 3'b100, 1'b1, 1'b0, "R6");
        cyc(1'b0, '0, 3'b0, 1'b0, 1'b1, "R7");

        // R3/R5: drain completely
        while (mq.size() > 0) cyc(1'b0, '0, 3'b0, 1'b1, 1'b0, "R3");
        // R4: empty reads zero
        cyc(1'b0, '0, 3'b0, 1'b1, 1'b0, "R4");

        // R9: simultaneous write and pop with mixed flags
        for (int i = 0; i < 5; i++) cyc(1'b1, pat_data(i + 100), pat_flag(i + 1), 1'b0, 1'b0, "R9");
        for (int i = 0; i < 40; i++)
            cyc(1'b1, pat_data(i + 200), (i % 3 == 0) ? 3'((i % 7) + 1) : 3'b0, 1'b1, 1'b0, "R9");
        while (mq.size() > 0) cyc(1'b0, '0, 3'b0, 1'b1, 1'b0, "R5");

        // R5: clean, error, clean — summary bit falls after the error leaves
        cyc(1'b1, 8'h11, 3'b000, 1'b0, 1'b0, "R5");
        cyc(1'b1, 8'h22, 3'b001, 1'b0, 1'b0, "R5");
        cyc(1'b1, 8'h33, 3'b000, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 3'b0, 1'b1, 1'b0, "R5");
        // R4: empty again, zero outputs
        cyc(1'b0, '0, 3'b0, 1'b0, 1'b0, "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule